// File: doc/BRIEF.md
# Descriptor Ring Ownership Engine

This block walks the transmit and receive descriptor rings of a 10/100 Ethernet MAC. Each descriptor is four 32-bit words on a 16-byte boundary. Word 0 is the status word, with the ownership flag in bit 31. Word 1 holds the control fields. Word 2 holds the buffer address, and word 3 is unused. Software fills a descriptor and sets the ownership flag to hand it to hardware. The engine fetches the descriptor, acts on it, writes the status word back with the flag cleared, and moves to the next slot. It goes back to the ring base after any slot whose control word carries the end-of-ring flag. There is no ring-length register.

The transmit side sleeps until a poll-demand pulse. It then works through hardware-owned descriptors until it meets one that software owns. At that point it signals that it has no transmit buffer and sleeps again. For each good descriptor it hands the frame length, the segment flags and the buffer address to the line side. It waits for the line side to report completion and then writes the descriptor back. The receive side is woken by a frame arriving from the line side. It checks the frame against the current descriptor and writes back the length and the error flags. A good frame is passed on to payload storage. A frame is dropped when software still owns the descriptor. Both sides share one single-word memory request port, and a pending receive frame is served first.

Top module: `desc_ring_engine`

## Requirements
- R1: After reset the engine issues no memory request and raises none of txStart, rxStore, noTxBuf or noRxBuf. Both ring indices start at slot 0.
- R2: The transmit side touches memory only after a txPoll pulse. Each fetch first reads word 0 at base + 16*index, and bit 31 of that word set means the descriptor is hardware-owned.
- R3: For a hardware-owned transmit descriptor the engine reads word 1 and word 2. It then pulses txStart for one cycle with txLen = word1[10:0], txFirst = word1[29], txLast = word1[28] and txBufAddr = word 2. After txDone it writes word 0 as zero and continues with the next slot.
- R4: On a software-owned transmit descriptor the engine pulses noTxBuf, leaves that descriptor unwritten and issues no further request until the next txPoll. That poll re-checks the same slot.
- R5: A descriptor whose word1[31] is set is followed by slot 0 of the same ring. Otherwise the index advances by one. This holds for both rings.
- R6: A transmit descriptor with an odd buffer address gives no txStart. Word 0 is written back with bit 17 set and the ownership flag clear, and the engine moves on.
- R7: A frame arriving on a hardware-owned receive descriptor causes word 0 to be written back with the frame length in bits [10:0] and bit 31 clear. A good frame also raises a one-cycle rxStore with rxBufAddr = word 2.
- R8: A frame flagged with rxFrameErr sets bit 16 of the written-back word 0 and gives no rxStore.
- R9: A frame longer than the buffer size in word1[10:0] sets bit 18 of word 0 and gives no rxStore. A length equal to the size is accepted.
- R10: A receive buffer address whose bits [1:0] are not 2'b10 sets bit 17 of word 0 and gives no rxStore. This covers both odd and word-aligned addresses.
- R11: A frame that meets a software-owned receive descriptor pulses noRxBuf and is dropped. The descriptor is not written and the receive index does not move.
- R12: A memory request holds its address and direction until memAck. No write ever sets the ownership flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txBase | input | 32 | Transmit ring base address, 16-byte aligned |
| rxBase | input | 32 | Receive ring base address, 16-byte aligned |
| txPoll | input | 1 | Transmit poll-demand pulse |
| txDone | input | 1 | Line side finished the frame handed over by txStart |
| txStart | output | 1 | One-cycle pulse: transmit the described buffer |
| txBufAddr | output | 32 | Transmit buffer address |
| txLen | output | 11 | Transmit frame length |
| txFirst | output | 1 | First-segment flag of the descriptor |
| txLast | output | 1 | Last-segment flag of the descriptor |
| noTxBuf | output | 1 | Pulse: current transmit descriptor is software-owned |
| rxFrameValid | input | 1 | Pulse: a frame has arrived from the line side |
| rxFrameLen | input | 11 | Length of the arriving frame |
| rxFrameErr | input | 1 | Arriving frame is in error |
| rxStore | output | 1 | One-cycle pulse: store the frame at rxBufAddr |
| rxBufAddr | output | 32 | Receive buffer address |
| noRxBuf | output | 1 | Pulse: frame dropped, descriptor software-owned |
| memReq | output | 1 | Memory request, held until memAck |
| memWrite | output | 1 | Request is a write |
| memAddr | output | 32 | Word address of the request (byte units) |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Request completed; memRdata valid for reads |
| memRdata | input | 32 | Read data |

## Verification
The bench goes after the wrap to slot 0, on both rings. An engine that ignores the end flag would fetch past the ring and treat a stale word as a descriptor. It goes after the stop on a software-owned transmit slot followed by a fresh poll. A design that skipped that slot, or that kept polling, would show an extra txStart or a missing noTxBuf. The receive corner cases are the halfword rule, where a word-aligned buffer must be rejected, and the exact-size boundary against a one-byte-over frame. A dropped frame must leave the index in place. An engine that advanced on a drop would put the next frame in the wrong slot, and the written-back status words would show it.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_TX_C0, S_TX_C1, S_TX_BUF, S_TX_GO, S_TX_WAIT, S_TX_WB,
    S_RX_C0, S_RX_C1, S_RX_BUF, S_RX_GO, S_RX_WB
  } engState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic       rxSide;   // address and write-back select the receive ring
    logic [1:0] wordSel;  // descriptor word being accessed
    logic       capCt1;   // capture control word
    logic       capBuf;   // capture buffer address
    logic       advTx;    // step the transmit index
    logic       advRx;    // step the receive index
    logic       latchRx;  // latch an arriving frame's length and error
  } ringStrobe_t;

  localparam int OWNER_BIT     = 31;
  localparam int END_BIT       = 31;
  localparam int FIRST_BIT     = 29;
  localparam int LAST_BIT      = 28;
  localparam int ERR_FRAME_BIT = 16;
  localparam int ERR_ADDR_BIT  = 17;
  localparam int ERR_SIZE_BIT  = 18;
  localparam int DESC_SHIFT    = 4;   // 16-byte descriptors

endpackage

// File: rtl/desc_ring_ctrl.sv
module desc_ring_ctrl
  import desc_ring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        txPoll,
  input  logic        txDone,
  input  logic        rxFrameValid,
  input  logic        memAck,
  input  logic        rdOwner,
  input  logic        bufBad,
  input  logic        rxGood,
  output ringStrobe_t st,
  output logic        memReq,
  output logic        memWrite,
  output logic        txStart,
  output logic        rxStore,
  output logic        noTxBuf,
  output logic        noRxBuf
);

  engState_t state, nextState;
  logic txActive, rxPend;
  logic txEmpty, rxEmpty;

  assign txEmpty = (state == S_TX_C0) && memAck && !rdOwner;
  assign rxEmpty = (state == S_RX_C0) && memAck && !rdOwner;

  always_comb begin
    nextState  = state;
    st         = '0;
    memReq     = 1'b0;
    memWrite   = 1'b0;
    st.rxSide  = state inside {S_RX_C0, S_RX_C1, S_RX_BUF, S_RX_GO, S_RX_WB};
    st.latchRx = rxFrameValid && !rxPend;
    case (state)
      S_IDLE: begin
        if (rxPend)        nextState = S_RX_C0;
        else if (txActive) nextState = S_TX_C0;
      end
      S_TX_C0, S_RX_C0: begin
        memReq = 1'b1;
        if (memAck) begin
          if (state == S_TX_C0) nextState = rdOwner ? S_TX_C1 : S_IDLE;
          else                  nextState = rdOwner ? S_RX_C1 : S_IDLE;
        end
      end
      S_TX_C1, S_RX_C1: begin
        memReq     = 1'b1;
        st.wordSel = 2'd1;
        st.capCt1  = memAck;
        if (memAck) nextState = (state == S_TX_C1) ? S_TX_BUF : S_RX_BUF;
      end
      S_TX_BUF, S_RX_BUF: begin
        memReq     = 1'b1;
        st.wordSel = 2'd2;
        st.capBuf  = memAck;
        if (memAck) nextState = (state == S_TX_BUF) ? S_TX_GO : S_RX_GO;
      end
      S_TX_GO:   nextState = bufBad ? S_TX_WB : S_TX_WAIT;
      S_TX_WAIT: if (txDone) nextState = S_TX_WB;
      S_RX_GO:   nextState = S_RX_WB;
      S_TX_WB, S_RX_WB: begin
        memReq   = 1'b1;
        memWrite = 1'b1;
        if (memAck) begin
          nextState = S_IDLE;
          if (state == S_TX_WB) st.advTx = 1'b1;
          else                  st.advRx = 1'b1;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign txStart = (state == S_TX_GO) && !bufBad;
  assign rxStore = (state == S_RX_GO) && rxGood;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      txActive <= 1'b0;
      rxPend   <= 1'b0;
      noTxBuf  <= 1'b0;
      noRxBuf  <= 1'b0;
    end else begin
      state   <= nextState;
      noTxBuf <= txEmpty;
      noRxBuf <= rxEmpty;
      if (txPoll)       txActive <= 1'b1;
      else if (txEmpty) txActive <= 1'b0;
      if (rxEmpty || (state == S_RX_WB && memAck)) rxPend <= 1'b0;
      else if (st.latchRx)                         rxPend <= 1'b1;
    end
  end

  // R4: an empty transmit slot leaves the engine idle
  a_r4_empty_goes_idle: assert property (@(posedge clk) disable iff (!rstN)
    noTxBuf |-> state == S_IDLE);

  // R3: transmit hand-over is a single-cycle pulse
  a_r3_start_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> !txStart);

  // R11: a dropped frame is no longer pending
  a_r11_drop_clears_pending: assert property (@(posedge clk) disable iff (!rstN)
    noRxBuf |-> !rxPend);

endmodule

// File: rtl/desc_ring_datapath.sv
module desc_ring_datapath
  import desc_ring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStrobe_t       st,
  input  logic [ADDR_W-1:0] txBase,
  input  logic [ADDR_W-1:0] rxBase,
  input  logic [31:0]       memRdata,
  input  logic [LEN_W-1:0]  rxFrameLen,
  input  logic              rxFrameErr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [ADDR_W-1:0] bufAddr,
  output logic [LEN_W-1:0]  txLen,
  output logic              txFirst,
  output logic              txLast,
  output logic              bufBad,
  output logic              rxGood
);

  logic [ADDR_W-1:0] bufQ;
  logic [LEN_W-1:0]  ct1Len, rxLenQ;
  logic              ct1End, ct1First, ct1Last, rxErrQ, tooLong;
  logic [1:0]        advVec;
  logic [IDX_W-1:0]  curIdx;
  logic [ADDR_W-1:0] curBase;

  assign advVec = {st.advRx, st.advTx};

  // one index counter per ring: 0 = transmit, 1 = receive
  for (genvar s = 0; s < 2; s++) begin : g_ring
    logic [IDX_W-1:0] idx;
    always_ff @(posedge clk) begin
      if (!rstN)          idx <= '0;
      else if (advVec[s]) idx <= ct1End ? '0 : idx + 1'b1;
    end
  end

  assign curIdx  = st.rxSide ? g_ring[1].idx : g_ring[0].idx;
  assign curBase = st.rxSide ? rxBase : txBase;
  assign memAddr = curBase + (ADDR_W'(curIdx) << DESC_SHIFT) + (ADDR_W'(st.wordSel) << 2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufQ     <= '0;
      ct1Len   <= '0;
      ct1End   <= 1'b0;
      ct1First <= 1'b0;
      ct1Last  <= 1'b0;
      rxLenQ   <= '0;
      rxErrQ   <= 1'b0;
    end else begin
      if (st.capCt1) begin
        ct1Len   <= memRdata[LEN_W-1:0];
        ct1End   <= memRdata[END_BIT];
        ct1First <= memRdata[FIRST_BIT];
        ct1Last  <= memRdata[LAST_BIT];
      end
      if (st.capBuf) bufQ <= memRdata[ADDR_W-1:0];
      if (st.latchRx) begin
        rxLenQ <= rxFrameLen;
        rxErrQ <= rxFrameErr;
      end
    end
  end

  assign tooLong = rxLenQ > ct1Len;
  assign bufBad  = st.rxSide ? (bufQ[1:0] != 2'b10) : bufQ[0];
  assign rxGood  = !bufBad && !tooLong && !rxErrQ;

  always_comb begin
    memWdata = '0;
    memWdata[ERR_ADDR_BIT] = bufBad;
    if (st.rxSide) begin
      memWdata[LEN_W-1:0]     = rxLenQ;
      memWdata[ERR_FRAME_BIT] = rxErrQ;
      memWdata[ERR_SIZE_BIT]  = tooLong;
    end
  end

  assign bufAddr = bufQ;
  assign txLen   = ct1Len;
  assign txFirst = ct1First;
  assign txLast  = ct1Last;

endmodule

// File: rtl/desc_ring_engine.sv
module desc_ring_engine
  import desc_ring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] txBase,
  input  logic [ADDR_W-1:0] rxBase,
  input  logic              txPoll,
  input  logic              txDone,
  output logic              txStart,
  output logic [ADDR_W-1:0] txBufAddr,
  output logic [LEN_W-1:0]  txLen,
  output logic              txFirst,
  output logic              txLast,
  output logic              noTxBuf,
  input  logic              rxFrameValid,
  input  logic [LEN_W-1:0]  rxFrameLen,
  input  logic              rxFrameErr,
  output logic              rxStore,
  output logic [ADDR_W-1:0] rxBufAddr,
  output logic              noRxBuf,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic              memAck,
  input  logic [31:0]       memRdata
);

  ringStrobe_t       st;
  logic              bufBad, rxGood;
  logic [ADDR_W-1:0] bufAddr;

  desc_ring_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .txPoll(txPoll), .txDone(txDone),
    .rxFrameValid(rxFrameValid), .memAck(memAck),
    .rdOwner(memRdata[OWNER_BIT]), .bufBad(bufBad), .rxGood(rxGood),
    .st(st), .memReq(memReq), .memWrite(memWrite), .txStart(txStart),
    .rxStore(rxStore), .noTxBuf(noTxBuf), .noRxBuf(noRxBuf)
  );

  desc_ring_datapath #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) i_dp (
    .clk(clk), .rstN(rstN), .st(st), .txBase(txBase), .rxBase(rxBase),
    .memRdata(memRdata), .rxFrameLen(rxFrameLen), .rxFrameErr(rxFrameErr),
    .memAddr(memAddr), .memWdata(memWdata), .bufAddr(bufAddr),
    .txLen(txLen), .txFirst(txFirst), .txLast(txLast),
    .bufBad(bufBad), .rxGood(rxGood)
  );

  assign txBufAddr = bufAddr;
  assign rxBufAddr = bufAddr;

  // R12: a request is held unchanged until acknowledged
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWrite));

  // R12: write-back always returns the descriptor to software
  a_r12_wb_owner_clear: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWrite |-> !memWdata[OWNER_BIT]);

  // R10: payload is only stored to a halfword-aligned, non-word-aligned buffer
  a_r10_store_halfword: assert property (@(posedge clk) disable iff (!rstN)
    rxStore |-> rxBufAddr[1:0] == 2'b10);

  // R6: transmit is never started from an odd buffer
  a_r6_start_even: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> !txBufAddr[0]);

endmodule

// File: tb/test_desc_ring_engine.sv
module test_desc_ring_engine;
  localparam logic [31:0] TXB = 32'h100;
  localparam logic [31:0] RXB = 32'h200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic        txPoll = 1'b0, txDone, txStart, txFirst, txLast, noTxBuf;
  logic [31:0] txBufAddr, rxBufAddr, memAddr, memWdata, memRdata;
  logic [10:0] txLen;
  logic        rxFrameValid = 1'b0, rxFrameErr = 1'b0, rxStore, noRxBuf;
  logic [10:0] rxFrameLen = '0;
  logic        memReq, memWrite, memAck;

  desc_ring_engine i_desc_ring_engine (
    .clk(clk), .rstN(rstN), .txBase(TXB), .rxBase(RXB),
    .txPoll(txPoll), .txDone(txDone), .txStart(txStart), .txBufAddr(txBufAddr),
    .txLen(txLen), .txFirst(txFirst), .txLast(txLast), .noTxBuf(noTxBuf),
    .rxFrameValid(rxFrameValid), .rxFrameLen(rxFrameLen), .rxFrameErr(rxFrameErr),
    .rxStore(rxStore), .rxBufAddr(rxBufAddr), .noRxBuf(noRxBuf),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata)
  );

  logic [31:0] mem [0:255];
  int vectors = 0, miscompares = 0;
  int txCnt = 0, rxCnt = 0, nTx = 0, nRx = 0, reqCnt = 0, ownerWr = 0;
  logic [31:0] txLogAddr [0:63];
  logic [10:0] txLogLen  [0:63];
  logic        txLogF    [0:63];
  logic        txLogL    [0:63];
  logic [31:0] rxLastAddr;

  function automatic int wIdx(logic [31:0] base, int slot, int word);
    return int'(base >> 2) + slot * 4 + word;
  endfunction

  function automatic logic [31:0] expRxWord(int len, bit err, int size, logic [31:0] b);
    logic [31:0] w = 32'(len) & 32'h7FF;
    if (err) w[16] = 1'b1;
    if (b[1:0] != 2'b10) w[17] = 1'b1;
    if (len > size) w[18] = 1'b1;
    return w;
  endfunction

  function automatic logic [31:0] txCtl(int len, bit f, bit l, bit e);
    return (32'(e) << 31) | (32'(f) << 29) | (32'(l) << 28) | (32'(len) & 32'h7FF);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic setTx(int i, bit own, int len, bit f, bit l, logic [31:0] b);
    mem[wIdx(TXB, i, 0)] = own ? 32'h8000_0000 : 32'h0000_1234;
    mem[wIdx(TXB, i, 1)] = txCtl(len, f, l, i == 2);
    mem[wIdx(TXB, i, 2)] = b;
  endtask

  task automatic setRx(int i, int size, logic [31:0] b);
    mem[wIdx(RXB, i, 0)] = 32'h8000_0000;
    mem[wIdx(RXB, i, 1)] = (32'(i == 3) << 31) | 32'(size);
    mem[wIdx(RXB, i, 2)] = b;
  endtask

  task automatic poll();
    @(negedge clk) txPoll = 1'b1;
    @(negedge clk) txPoll = 1'b0;
    repeat (150) @(negedge clk);
  endtask

  task automatic sendRx(int len, bit err);
    @(negedge clk);
    rxFrameValid = 1'b1; rxFrameLen = 11'(len); rxFrameErr = err;
    @(negedge clk) rxFrameValid = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  // memory responder with random latency
  initial begin
    int lat = 0;
    memAck = 1'b0; memRdata = '0;
    forever begin
      @(negedge clk);
      if (memAck) memAck = 1'b0;
      else if (memReq) begin
        if (lat == 0) begin
          memAck = 1'b1;
          memRdata = mem[memAddr[9:2]];
          if (memWrite) begin
            mem[memAddr[9:2]] = memWdata;
            if (memWdata[31]) ownerWr++;
          end
          lat = int'($urandom % 3);
        end else lat--;
      end
    end
  end

  // line-side transmit completion
  initial begin
    txDone = 1'b0;
    forever begin
      @(negedge clk);
      if (txStart) begin
        repeat (1 + $urandom % 3) @(negedge clk);
        txDone = 1'b1;
        @(negedge clk) txDone = 1'b0;
      end
    end
  end

  // monitor
  initial forever begin
    @(negedge clk);
    if (rstN && memReq) reqCnt++;
    if (txStart && txCnt < 64) begin
      txLogAddr[txCnt] = txBufAddr; txLogLen[txCnt] = txLen;
      txLogF[txCnt] = txFirst; txLogL[txCnt] = txLast;
      txCnt++;
    end
    if (rxStore) begin rxCnt++; rxLastAddr = rxBufAddr; end
    if (noTxBuf) nTx++;
    if (noRxBuf) nRx++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    report();
  end

  initial begin
    int len [0:7];
    logic [31:0] bufs [0:7];
    int txI, rxI, c0, r0;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 memReq in reset", {31'b0, memReq}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 memReq", {31'b0, memReq}, 0);
    chk("R1 pulses", {28'b0, txStart, rxStore, noTxBuf, noRxBuf}, 0);

    // R2: owned descriptor is not fetched without a poll
    for (int i = 0; i < 3; i++) setTx(i, 0, 60, 0, 0, 32'h400);
    setTx(0, 1, 100, 1, 1, 32'h1000);
    repeat (30) @(negedge clk);
    chk("R2 no fetch before poll", 32'(reqCnt), 0);

    // R3/R4: two owned slots, third empty
    len[0] = 60 + int'($urandom % 1477); bufs[0] = $urandom & 32'hFFFF_FFFE;
    len[1] = 60 + int'($urandom % 1477); bufs[1] = $urandom & 32'hFFFF_FFFC;
    setTx(0, 1, len[0], 1, 0, bufs[0]);
    setTx(1, 1, len[1], 0, 1, bufs[1]);
    poll();
    chk("R3 start count", 32'(txCnt), 2);
    chk("R3 addr slot0", txLogAddr[0], bufs[0]);
    chk("R3 len slot0", 32'(txLogLen[0]), 32'(len[0]));
    chk("R3 flags slot0", {30'b0, txLogF[0], txLogL[0]}, 2'b10);
    chk("R3 addr slot1", txLogAddr[1], bufs[1]);
    chk("R3 len slot1", 32'(txLogLen[1]), 32'(len[1]));
    chk("R3 flags slot1", {30'b0, txLogF[1], txLogL[1]}, 2'b01);
    chk("R3 writeback slot0", mem[wIdx(TXB, 0, 0)], 0);
    chk("R3 writeback slot1", mem[wIdx(TXB, 1, 0)], 0);
    chk("R4 empty slot untouched", mem[wIdx(TXB, 2, 0)], 32'h1234);
    chk("R4 noTxBuf", 32'(nTx), 1);

    // R4/R5: re-check same slot on poll, then wrap
    len[2] = 60 + int'($urandom % 1477); bufs[2] = $urandom & 32'hFFFF_FFFE;
    len[3] = 60 + int'($urandom % 1477); bufs[3] = $urandom & 32'hFFFF_FFFE;
    setTx(2, 1, len[2], 1, 1, bufs[2]);
    setTx(0, 1, len[3], 1, 1, bufs[3]);
    setTx(1, 0, 60, 0, 0, 32'h400);
    c0 = reqCnt;
    repeat (40) @(negedge clk);
    chk("R4 idle until poll", 32'(reqCnt - c0), 0);
    poll();
    chk("R4 count after poll", 32'(txCnt), 4);
    chk("R4 same slot rechecked", txLogAddr[2], bufs[2]);
    chk("R5 tx wrap to slot0", txLogAddr[3], bufs[3]);
    chk("R5 tx wrap len", 32'(txLogLen[3]), 32'(len[3]));
    chk("R4 second noTxBuf", 32'(nTx), 2);

    // R6: odd buffer skipped
    setTx(1, 1, 200, 1, 1, 32'h0000_3001);
    setTx(2, 1, 300, 1, 1, 32'h0000_5002);
    poll();
    chk("R6 no start for odd buffer", 32'(txCnt), 5);
    chk("R6 next slot served", txLogAddr[4], 32'h0000_5002);
    chk("R6 status word", mem[wIdx(TXB, 1, 0)], 32'h0002_0000);
    chk("R6 stop after", 32'(nTx), 3);

    // random transmit rounds
    txI = 0;
    for (int k = 0; k < 8; k++) begin
      int l = 60 + int'($urandom % 1477);
      logic [31:0] b = $urandom & 32'hFFFF_FFFE;
      c0 = txCnt;
      setTx(txI, 1, l, 1, 1, b);
      poll();
      chk("R3 random start", 32'(txCnt - c0), 1);
      chk("R3 random addr", txLogAddr[c0], b);
      chk("R3 random len", 32'(txLogLen[c0]), 32'(l));
      txI = (txI == 2) ? 0 : txI + 1;
    end

    // receive directed cases
    for (int i = 0; i < 4; i++) bufs[i] = ($urandom & 32'hFFFF_FFFC) | 32'h2;
    setRx(0, 1536, bufs[0]);
    setRx(1, 1536, bufs[1]);
    setRx(2, 100, bufs[2]);
    setRx(3, 1536, bufs[3] & 32'hFFFF_FFFC);
    len[0] = 1 + int'($urandom % 1536);
    sendRx(len[0], 0);
    chk("R7 status slot0", mem[wIdx(RXB, 0, 0)], expRxWord(len[0], 0, 1536, bufs[0]));
    chk("R7 store count", 32'(rxCnt), 1);
    chk("R7 store addr", rxLastAddr, bufs[0]);
    len[1] = 1 + int'($urandom % 1536);
    sendRx(len[1], 1);
    chk("R8 frame error", mem[wIdx(RXB, 1, 0)], expRxWord(len[1], 1, 1536, bufs[1]));
    chk("R8 no store", 32'(rxCnt), 1);
    sendRx(101, 0);
    chk("R9 oversize", mem[wIdx(RXB, 2, 0)], expRxWord(101, 0, 100, bufs[2]));
    chk("R9 no store", 32'(rxCnt), 1);
    sendRx(500, 0);
    chk("R10 word-aligned buffer", mem[wIdx(RXB, 3, 0)],
        expRxWord(500, 0, 1536, bufs[3] & 32'hFFFF_FFFC));
    chk("R10 no store", 32'(rxCnt), 1);
    sendRx(77, 0);
    chk("R11 noRxBuf", 32'(nRx), 1);
    chk("R11 descriptor untouched", mem[wIdx(RXB, 0, 0)], expRxWord(len[0], 0, 1536, bufs[0]));
    setRx(0, 100, bufs[0]);
    sendRx(100, 0);
    chk("R5 rx wrap and R11 index held", mem[wIdx(RXB, 0, 0)], 32'd100);
    chk("R9 exact size stored", 32'(rxCnt), 2);
    setRx(1, 1536, 32'h0000_7003);
    sendRx(64, 0);
    chk("R10 odd buffer", mem[wIdx(RXB, 1, 0)], expRxWord(64, 0, 1536, 32'h0000_7003));

    // random receive rounds
    rxI = 2;
    for (int k = 0; k < 8; k++) begin
      int l = 1 + int'($urandom % 1536);
      logic [31:0] b = ($urandom & 32'hFFFF_FFFC) | 32'h2;
      r0 = rxCnt;
      setRx(rxI, 1536, b);
      sendRx(l, 0);
      chk("R7 random status", mem[wIdx(RXB, rxI, 0)], 32'(l));
      chk("R7 random store", 32'(rxCnt - r0), 1);
      chk("R7 random addr", rxLastAddr, b);
      rxI = (rxI == 3) ? 0 : rxI + 1;
    end

    chk("R12 no owner-set writes", 32'(ownerWr), 0);
    report();
  end

endmodule